// File: doc/BRIEF.md
# GPIO Bank Override and Pass-Through Router

This block drives groups of general-purpose lines, one group (bank) per paired input/output channel. In normal operation each line of a bank repeats the matching line arriving from its partner channel, but only where routing for that line is switched on. Bank 0 pairs with channel 0, bank 1 with channel 1, and so on. A host can take over any line: it picks a bank and presents a value word and an enable mask. On an update strobe these words are captured into that bank's holding registers. From then on, every line with its held enable set drives the held value, whatever its route says. A line with neither a held enable nor a route is released (output enable low, drive value low).

The host also reads back the live level of every line in the selected bank. Each line passes through a synchronizer before the bank multiplexer. The bank selection and the routing mask are plain inputs, so either can change at any time while the block runs.

Top module: `gpio_bank_router`

## Requirements
- R1: After reset every holding register is clear, so pad enables follow the routing mask only, and the readback word is zero until pad levels have passed the synchronizer.
- R2: When `host_upd` is high at a rising clock edge, `host_val` and `host_oe` are captured for the bank given by `bank_sel`. The pads of that bank show the new values right after that edge.
- R3: An update writes only the selected bank; the held values of every other bank are unchanged.
- R4: Changes on `host_val` or `host_oe` without `host_upd` have no effect on `pad_out` or `pad_oe`.
- R5: A line whose held enable is 1 has `pad_oe` = 1 and `pad_out` = held value, even when its route bit is set.
- R6: A line with held enable 0 and route bit 1 has `pad_oe` = 1 and `pad_out` equal to the same-index bit of `route_src`, with no clock delay. Line index = bank × lines-per-bank + line, in all flattened ports.
- R7: A line with held enable 0 and route bit 0 has `pad_oe` = 0 and `pad_out` = 0.
- R8: `rd_data` shows the lines of the selected bank from `pad_in` as sampled two rising edges earlier (two-flop synchronizer).
- R9: A change of `bank_sel` or `route_en` acts at once, without a clock edge, on `rd_data` and on the pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_src | input | NB*NL | Line levels from the partner channels |
| route_en | input | NB*NL | Per-line pass-through enable |
| bank_sel | input | SELW | Bank addressed by update and readback |
| host_val | input | NL | Host drive values for the selected bank |
| host_oe | input | NL | Host output-enable mask for the selected bank |
| host_upd | input | 1 | Update strobe capturing value and mask |
| pad_in | input | NB*NL | Live line levels seen at the pads |
| pad_out | output | NB*NL | Pad drive values |
| pad_oe | output | NB*NL | Pad output enables |
| rd_data | output | NL | Synchronized levels of the selected bank |

## Verification
Route and bank-select effects are combinational, so the bench checks them in the same cycle they are driven, half a period later. A host update is due right after the edge that samples the strobe, so pads are compared at the next falling edge. Readback trails `pad_in` by two rising edges. The bench keeps a two-deep model pipeline and checks both the old value after one edge and the new value after the second.

// File: rtl/gpio_rt_pkg.sv
package gpio_rt_pkg;
   function automatic int sel_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/gpio_hold_bank.sv
module gpio_hold_bank #(
   parameter int NB   = 4,
   parameter int NL   = 8,
   parameter int SELW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SELW-1:0]   bank_sel,
   input  logic [NL-1:0]     host_val,
   input  logic [NL-1:0]     host_oe,
   input  logic              host_upd,
   output logic [NB*NL-1:0]  hold_val,
   output logic [NB*NL-1:0]  hold_oe
);
   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic wr_hit;
      assign wr_hit = host_upd && (int'(bank_sel) == b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_val[b*NL +: NL] <= '0;
            hold_oe[b*NL +: NL]  <= '0;
         end else if (wr_hit) begin
            hold_val[b*NL +: NL] <= host_val;
            hold_oe[b*NL +: NL]  <= host_oe;
         end
      end
   end
endmodule

// File: rtl/gpio_line_mux.sv
module gpio_line_mux #(
   parameter int NLINES = 32
) (
   input  logic [NLINES-1:0] hold_val,
   input  logic [NLINES-1:0] hold_oe,
   input  logic [NLINES-1:0] route_src,
   input  logic [NLINES-1:0] route_en,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe
);
   for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_comb begin
         if (hold_oe[i]) begin
            pad_oe[i]  = 1'b1;
            pad_out[i] = hold_val[i];
         end else if (route_en[i]) begin
            pad_oe[i]  = 1'b1;
            pad_out[i] = route_src[i];
         end else begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/gpio_rd_sync.sv
module gpio_rd_sync #(
   parameter int NB          = 4,
   parameter int NL          = 8,
   parameter int SELW        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NB*NL-1:0]  pad_in,
   input  logic [SELW-1:0]   bank_sel,
   output logic [NL-1:0]     rd_data
);
   localparam int W = NB * NL;
   logic [W-1:0] stg [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= pad_in;
         for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   if ((1 << SELW) > NB) begin : g_guard
      always_comb begin
         rd_data = '0;
         for (int b = 0; b < NB; b++)
            if (int'(bank_sel) == b) rd_data = stg[SYNC_STAGES-1][b*NL +: NL];
      end
   end else begin : g_direct
      assign rd_data = stg[SYNC_STAGES-1][bank_sel*NL +: NL];
   end
endmodule

// File: rtl/gpio_bank_router.sv
module gpio_bank_router
   import gpio_rt_pkg::*;
#(
   parameter int NB          = 4,
   parameter int NL          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SELW        = sel_width(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NB*NL-1:0]  route_src,
   input  logic [NB*NL-1:0]  route_en,
   input  logic [SELW-1:0]   bank_sel,
   input  logic [NL-1:0]     host_val,
   input  logic [NL-1:0]     host_oe,
   input  logic              host_upd,
   input  logic [NB*NL-1:0]  pad_in,
   output logic [NB*NL-1:0]  pad_out,
   output logic [NB*NL-1:0]  pad_oe,
   output logic [NL-1:0]     rd_data
);
   localparam int W = NB * NL;

   initial begin
      if (NB < 2)          $error("NB must be at least 2");
      if (NL < 1)          $error("NL must be at least 1");
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if ((1 << SELW) < NB) $error("SELW too narrow for NB");
   end

   logic [W-1:0] hold_val;
   logic [W-1:0] hold_oe;

   gpio_hold_bank #(.NB(NB), .NL(NL), .SELW(SELW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .bank_sel (bank_sel),
      .host_val (host_val),
      .host_oe  (host_oe),
      .host_upd (host_upd),
      .hold_val (hold_val),
      .hold_oe  (hold_oe)
   );

   gpio_line_mux #(.NLINES(W)) u_mux (
      .hold_val  (hold_val),
      .hold_oe   (hold_oe),
      .route_src (route_src),
      .route_en  (route_en),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   gpio_rd_sync #(.NB(NB), .NL(NL), .SELW(SELW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .bank_sel (bank_sel),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/gpio_bank_router_chk.sv
module gpio_bank_router_chk #(
   parameter int NB          = 4,
   parameter int NL          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SELW        = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NB*NL-1:0]  route_src,
   input logic [NB*NL-1:0]  route_en,
   input logic [SELW-1:0]   bank_sel,
   input logic [NL-1:0]     host_val,
   input logic [NL-1:0]     host_oe,
   input logic              host_upd,
   input logic [NB*NL-1:0]  pad_in,
   input logic [NB*NL-1:0]  pad_out,
   input logic [NB*NL-1:0]  pad_oe,
   input logic [NL-1:0]     rd_data
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   p_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & route_en) == route_en);

   p_nostrobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !host_upd |=> (!$stable(route_en) || !$stable(route_src) ||
                     ($stable(pad_oe) && $stable(pad_out))));

   for (genvar b = 0; b < NB; b++) begin : g_b
      p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (host_upd && int'(bank_sel) == b) |=>
            (((pad_oe[b*NL +: NL] & $past(host_oe)) == $past(host_oe)) &&
             ((pad_out[b*NL +: NL] & $past(host_oe)) == ($past(host_val) & $past(host_oe)))));

      if (SYNC_STAGES == 2) begin : g_s2
         p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && int'(bank_sel) == b) |->
               rd_data == $past(pad_in[b*NL +: NL], 2));
      end
   end
endmodule

bind gpio_bank_router gpio_bank_router_chk #(
   .NB(NB), .NL(NL), .SYNC_STAGES(SYNC_STAGES), .SELW(SELW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .route_src(route_src), .route_en(route_en),
   .bank_sel(bank_sel), .host_val(host_val), .host_oe(host_oe),
   .host_upd(host_upd), .pad_in(pad_in), .pad_out(pad_out),
   .pad_oe(pad_oe), .rd_data(rd_data)
);

// File: tb/sim_gpio_bank_router.sv
`timescale 1ns/1ps
module sim_gpio_bank_router;
   localparam int NB = 4;
   localparam int NL = 8;
   localparam int W = NB * NL;
   localparam int SELW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] route_src = '0, route_en = '0, pad_in = '0;
   logic [SELW-1:0] bank_sel = '0;
   logic [NL-1:0] host_val = '0, host_oe = '0;
   logic host_upd = 1'b0;
   logic [W-1:0] pad_out, pad_oe;
   logic [NL-1:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   logic [NL-1:0] m_hv [NB];
   logic [NL-1:0] m_ho [NB];
   logic [W-1:0] m_s1, m_s2;

   always #2.5 clk = ~clk;

   gpio_bank_router #(.NB(NB), .NL(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .route_src(route_src), .route_en(route_en),
      .bank_sel(bank_sel), .host_val(host_val), .host_oe(host_oe),
      .host_upd(host_upd), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .rd_data(rd_data)
   );

   function automatic logic [W-1:0] exp_oe();
      logic [W-1:0] r;
      for (int b = 0; b < NB; b++)
         for (int l = 0; l < NL; l++)
            r[b*NL+l] = m_ho[b][l] | route_en[b*NL+l];
      return r;
   endfunction

   function automatic logic [W-1:0] exp_out();
      logic [W-1:0] r;
      for (int b = 0; b < NB; b++)
         for (int l = 0; l < NL; l++)
            r[b*NL+l] = m_ho[b][l] ? m_hv[b][l] :
                        (route_en[b*NL+l] ? route_src[b*NL+l] : 1'b0);
      return r;
   endfunction

   function automatic logic [NL-1:0] exp_rd();
      return m_s2[int'(bank_sel)*NL +: NL];
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_pads(input string tag);
      chk({tag, " oe"}, pad_oe, exp_oe());
      chk({tag, " out"}, pad_out, exp_out());
   endtask

   task automatic chk_rd(input string tag);
      chk(tag, W'(rd_data), W'(exp_rd()));
   endtask

   // one rising edge: model follows the inputs the bench drove, then wait to the falling edge
   task automatic step();
      @(posedge clk);
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin m_hv[b] = '0; m_ho[b] = '0; end
         m_s1 = '0; m_s2 = '0;
      end else begin
         if (host_upd) begin
            m_hv[int'(bank_sel)] = host_val;
            m_ho[int'(bank_sel)] = host_oe;
         end
         m_s2 = m_s1;
         m_s1 = pad_in;
      end
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      for (int b = 0; b < NB; b++) begin m_hv[b] = '0; m_ho[b] = '0; end
      m_s1 = '0; m_s2 = '0;
      pad_in = 32'hDEAD_BEEF;
      repeat (3) step();
      rst_n = 1'b1;
      #1;
      // R1: cleared holding regs, no route, readback zero
      chk("R1 oe", pad_oe, '0);
      chk("R1 rd", W'(rd_data), '0);
      chk_pads("R1");

      // R6: pass-through with no clock delay
      route_en = '1; route_src = 32'h1234_5678;
      #1 chk_pads("R6 route");

      // R2 / R5: update bank 1, route also on
      bank_sel = 2'd1; host_val = 8'hA5; host_oe = 8'hF0; host_upd = 1'b1;
      step();
      host_upd = 1'b0;
      chk_pads("R2");
      chk("R5 prio", W'(pad_out[NL +: NL] & 8'hF0), W'(8'hA0));

      // R3: update bank 2, bank 1 unchanged
      bank_sel = 2'd2; host_val = 8'h3C; host_oe = 8'hFF; host_upd = 1'b1;
      step();
      host_upd = 1'b0;
      chk_pads("R3");
      chk("R3 b1", W'(pad_out[NL +: NL] & 8'hF0), W'(8'hA0));

      // R4: no strobe, words change, pads keep
      host_val = 8'h00; host_oe = 8'h0F;
      step(); step();
      chk_pads("R4");

      // R7: drop routes, clear bank 2 via update
      route_en = '0;
      bank_sel = 2'd2; host_val = 8'hFF; host_oe = 8'h00; host_upd = 1'b1;
      step();
      host_upd = 1'b0;
      chk_pads("R7");
      chk("R7 b0", W'(pad_oe[0 +: NL]), '0);

      // R8: readback two edges late
      bank_sel = 2'd3; pad_in = 32'h5A00_0000;
      step();
      chk_rd("R8 one edge");
      step();
      chk_rd("R8 two edges");
      chk("R8 value", W'(rd_data), W'(8'h5A));

      // R9: bank select and route take effect without an edge
      pad_in = 32'h0011_2233; step(); step();
      bank_sel = 2'd1;
      #1 chk("R9 rd", W'(rd_data), W'(8'h22));
      route_en = 32'h0000_FF00; route_src = 32'h0000_5500;
      #1 chk_pads("R9 route");

      // random mix
      for (int i = 0; i < 400; i++) begin
         route_src = $urandom(); route_en = $urandom(); pad_in = $urandom();
         bank_sel = SELW'($urandom_range(0, NB-1));
         host_val = NL'($urandom()); host_oe = NL'($urandom());
         host_upd = ($urandom_range(0, 3) == 0);
         step();
         chk_pads("R6 rand");
         chk_rd("R8 rand");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule